// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a synchronous request port to an external asynchronous static memory that is 32 bits wide and has 128K words. The memory is split into four 8-bit byte lanes, and each lane has its own active-low chip select. A single read or write request arrives on a valid/ready handshake. Each request carries a word address, write data and a 4-bit lane mask.

The controller turns each request into a fixed run of phases on the memory pins. Every phase lasts a whole number of clock cycles. Each count comes from a time parameter in picoseconds: the time is divided by the clock period, rounded up, and never allowed below one cycle. This keeps the memory's setup, pulse-width, access and recovery minimums on any clock.

- A write has three phases:
  - a setup phase, with the address and lane selects applied and the bus driven;
  - a pulse phase, with write enable low;
  - a hold phase, in which select and write enable rise together while the data stays driven.
- A read has two phases:
  - a turnaround phase, with the bus released;
  - an access phase, with output enable low.

Both kinds of request end in a recovery phase.

Read data is captured on the last access cycle. Lanes that are not enabled come back as zero. A one-cycle strobe marks the returned word. The bidirectional data bus appears as three ports: a drive value, a drive enable and a sampled input.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever idle, `req_ready_o` is 1. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` then stays 0 through the last recovery cycle, and while idle the pins stay deselected: all selects high, write enable high, output enable high, bus not driven.
- R2: A write follows this order:
  - Setup: the enabled lanes are selected, write enable is high and the bus is driven.
  - Pulse: write enable is low.
  - Hold (one cycle): all selects and write enable are high, and the bus is still driven.
  - Recovery: the bus is released.
- R3: The address and write data on the pins do not change from the first setup cycle to the end of the hold cycle.
- R4: Output enable and bus drive are never active together. Output enable falls only after the bus has been released for at least one full cycle.
- R5: A read follows this order:
  - Turnaround (one cycle): the enabled lanes are selected and output enable is high.
  - Access: the enabled lanes are selected and output enable is low.
  - Write enable stays high for the whole read.
- R6: Read data is registered at the end of the last access cycle. Byte l of `rd_data_o` holds bits [8l+7:8l] of the bus if mask bit l is 1, and zero otherwise. `rd_valid_o` is high for exactly one cycle, the first recovery cycle.
- R7: Each phase lasts ceil(time / clock period) cycles, with a minimum of 1. With the defaults (20 ns clock, 25 ns pulse, 45 ns access, 15 ns recovery, 0 ns setup and hold), the phases last as follows:
  - write: setup 1, pulse 2, hold 1, recovery 1 cycle;
  - read: turnaround 1, access 3, recovery 1 cycle;
  - `req_ready_o` is 0 for 5 cycles after acceptance in either case.
- R8: Mask bit l drives select bit l, and lane l is the bus bits [8l+7:8l]. A lane whose mask bit is 0 keeps its select high for the whole request, so a write leaves that byte in memory unchanged.
- R9: An asynchronous low on `rst_ni` returns every memory pin to the deselected state at once, even in the middle of a write pulse, and makes the controller idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Word address |
| req_wdata_i | input | 32 | Write data |
| req_be_i | input | 4 | Lane mask, bit l = byte lane l |
| rd_valid_o | output | 1 | One-cycle read data strobe |
| rd_data_o | output | 32 | Read data, disabled lanes zero |
| sram_addr_o | output | 17 | Memory address |
| sram_cs_no | output | 4 | Per-lane chip selects, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_dq_o | output | 32 | Value driven onto the data bus |
| sram_dq_oe_o | output | 1 | Data bus drive enable |
| sram_dq_i | input | 32 | Value sampled from the data bus |

## Verification
Two events share a single clock edge, and both are tested.

The first is the read capture. It happens on the same edge that raises the selects and output enable. The memory model in the bench drops its bytes and shows a filler pattern as soon as the read condition ends, so a late capture would return the filler instead of the stored bytes. Each returned word is compared with a value worked out from the earlier writes.

The second is the end of a write. Select and write enable rise on the same edge while the data is still held on the bus. The bench checks that the hold cycle still drives the bus. It then reads the word back, including lanes that were masked off, to confirm that the right bytes were stored and the others were left alone.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WR_SETUP,
    PH_WR_PULSE,
    PH_WR_HOLD,
    PH_RD_TURN,
    PH_RD_ACCESS,
    PH_RECOVER
  } phase_e;

  // round a time up to whole clock cycles, never below one
  function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                               input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= len_i - CNT_W'(1);
    else if (cnt_q != '0)       cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned SU_CYC = 1,
  parameter int unsigned PW_CYC = 1,
  parameter int unsigned WH_CYC = 1,
  parameter int unsigned TA_CYC = 1,
  parameter int unsigned AC_CYC = 1,
  parameter int unsigned RC_CYC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             last_i,
  output logic             ready_o,
  output phase_e           phase_q_o,
  output phase_e           phase_d_o,
  output logic             load_o,
  output logic [CNT_W-1:0] len_o
);

  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:      if (req_valid_i) phase_d = req_we_i ? PH_WR_SETUP : PH_RD_TURN;
      PH_WR_SETUP:  if (last_i) phase_d = PH_WR_PULSE;
      PH_WR_PULSE:  if (last_i) phase_d = PH_WR_HOLD;
      PH_WR_HOLD:   if (last_i) phase_d = PH_RECOVER;
      PH_RD_TURN:   if (last_i) phase_d = PH_RD_ACCESS;
      PH_RD_ACCESS: if (last_i) phase_d = PH_RECOVER;
      PH_RECOVER:   if (last_i) phase_d = PH_IDLE;
      default:      phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (phase_d)
      PH_WR_SETUP:  len_o = CNT_W'(SU_CYC);
      PH_WR_PULSE:  len_o = CNT_W'(PW_CYC);
      PH_WR_HOLD:   len_o = CNT_W'(WH_CYC);
      PH_RD_TURN:   len_o = CNT_W'(TA_CYC);
      PH_RD_ACCESS: len_o = CNT_W'(AC_CYC);
      PH_RECOVER:   len_o = CNT_W'(RC_CYC);
      default:      len_o = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign load_o    = (phase_d != phase_q);
  assign ready_o   = (phase_q == PH_IDLE);
  assign phase_q_o = phase_q;
  assign phase_d_o = phase_d;

  // R1
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ready_o) |=> !ready_o);

  // R1
  idle_from_recover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(phase_q == PH_RECOVER));

endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_be_i,
  input  phase_e            phase_q_i,
  input  phase_e            phase_d_i,
  input  logic              last_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [LANES-1:0]  sram_cs_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int unsigned LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q, be_nxt;
  logic [LANES-1:0]  cs_n_d, cs_n_q;
  logic              we_n_d, we_n_q, oe_n_d, oe_n_q, drv_d, drv_q;
  logic [DATA_W-1:0] rd_mask_data, rd_data_q;
  logic              rd_valid_q, capture;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept_i) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      be_q    <= req_be_i;
    end
  end

  assign be_nxt = accept_i ? req_be_i : be_q;

  // pins are decoded from the next phase and registered: glitch-free strobes
  always_comb begin
    cs_n_d = '1;
    we_n_d = 1'b1;
    oe_n_d = 1'b1;
    drv_d  = 1'b0;
    unique case (phase_d_i)
      PH_WR_SETUP:  begin cs_n_d = ~be_nxt; drv_d = 1'b1; end
      PH_WR_PULSE:  begin cs_n_d = ~be_nxt; drv_d = 1'b1; we_n_d = 1'b0; end
      PH_WR_HOLD:   drv_d = 1'b1;
      PH_RD_TURN:   cs_n_d = ~be_nxt;
      PH_RD_ACCESS: begin cs_n_d = ~be_nxt; oe_n_d = 1'b0; end
      default:      ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_q <= '1;
      we_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      drv_q  <= 1'b0;
    end else begin
      cs_n_q <= cs_n_d;
      we_n_q <= we_n_d;
      oe_n_q <= oe_n_d;
      drv_q  <= drv_d;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_mask_data[l*LANE_W +: LANE_W] =
      be_q[l] ? sram_dq_i[l*LANE_W +: LANE_W] : '0;
  end

  assign capture = (phase_q_i == PH_RD_ACCESS) && last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= capture;
      if (capture) rd_data_q <= rd_mask_data;
    end
  end

  assign sram_addr_o  = addr_q;
  assign sram_cs_no   = cs_n_q;
  assign sram_we_no   = we_n_q;
  assign sram_oe_no   = oe_n_q;
  assign sram_dq_o    = wdata_q;
  assign sram_dq_oe_o = drv_q;
  assign rd_data_o    = rd_data_q;
  assign rd_valid_o   = rd_valid_q;

  // R2
  wr_end_together_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_q) |-> ((&cs_n_q) && drv_q));

  // R3
  wr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_n_q || phase_q_i == PH_WR_HOLD) |-> ($stable(addr_q) && $stable(wdata_q)));

  // R4
  bus_oe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |-> oe_n_q);

  // R4
  turn_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_n_q) |-> (!drv_q && $past(!drv_q)));

  // R5
  read_we_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_q |-> we_n_q);

  // R6
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_q |=> !rd_valid_q);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W         = 17,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned LANES          = 4,
  parameter int unsigned CNT_W          = 8,
  parameter int unsigned CLK_PERIOD_PS  = 20000,
  parameter int unsigned T_WR_SETUP_PS  = 0,
  parameter int unsigned T_WR_PULSE_PS  = 25000,
  parameter int unsigned T_WR_HOLD_PS   = 0,
  parameter int unsigned T_RD_ACCESS_PS = 45000,
  parameter int unsigned T_RECOVER_PS   = 15000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_be_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [LANES-1:0]  sram_cs_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int unsigned SU_CYC = ps_to_cycles(T_WR_SETUP_PS,  CLK_PERIOD_PS);
  localparam int unsigned PW_CYC = ps_to_cycles(T_WR_PULSE_PS,  CLK_PERIOD_PS);
  localparam int unsigned WH_CYC = ps_to_cycles(T_WR_HOLD_PS,   CLK_PERIOD_PS);
  localparam int unsigned AC_CYC = ps_to_cycles(T_RD_ACCESS_PS, CLK_PERIOD_PS);
  localparam int unsigned RC_CYC = ps_to_cycles(T_RECOVER_PS,   CLK_PERIOD_PS);
  localparam int unsigned TA_CYC = 1;

  phase_e           phase_q, phase_d;
  logic             load, last, ready;
  logic [CNT_W-1:0] len;

  sram_lane_seq #(
    .CNT_W (CNT_W),
    .SU_CYC(SU_CYC), .PW_CYC(PW_CYC), .WH_CYC(WH_CYC),
    .TA_CYC(TA_CYC), .AC_CYC(AC_CYC), .RC_CYC(RC_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_we_i   (req_we_i),
    .last_i     (last),
    .ready_o    (ready),
    .phase_q_o  (phase_q),
    .phase_d_o  (phase_d),
    .load_o     (load),
    .len_o      (len)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .len_i (len),
    .last_o(last)
  );

  sram_lane_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (req_valid_i && ready),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_be_i    (req_be_i),
    .phase_q_i   (phase_q),
    .phase_d_i   (phase_d),
    .last_i      (last),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .sram_addr_o (sram_addr_o),
    .sram_cs_no  (sram_cs_no),
    .sram_we_no  (sram_we_no),
    .sram_oe_no  (sram_oe_no),
    .sram_dq_o   (sram_dq_o),
    .sram_dq_oe_o(sram_dq_oe_o),
    .sram_dq_i   (sram_dq_i)
  );

  assign req_ready_o = ready;

endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

  typedef struct packed {
    logic        we;
    logic [16:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  // expected read values follow from the earlier writes in the table
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 17'h00010, 4'hF, 32'hA1B2C3D4, 32'h0},
    '{1'b0, 17'h00010, 4'hF, 32'h0,        32'hA1B2C3D4},
    '{1'b1, 17'h00010, 4'h5, 32'h11223344, 32'h0},
    '{1'b0, 17'h00010, 4'hF, 32'h0,        32'hA122C344},
    '{1'b0, 17'h00010, 4'hA, 32'h0,        32'hA100C300},
    '{1'b1, 17'h1FFFF, 4'hF, 32'hDEADBEEF, 32'h0},
    '{1'b0, 17'h1FFFF, 4'h1, 32'h0,        32'h000000EF},
    '{1'b1, 17'h00000, 4'h8, 32'h55667788, 32'h0},
    '{1'b0, 17'h00000, 4'hF, 32'h0,        32'h55000000},
    '{1'b0, 17'h1FFFF, 4'hF, 32'h0,        32'hDEADBEEF}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, rd_valid;
  logic [31:0] rd_data;
  logic [16:0] sram_addr;
  logic [3:0]  sram_cs_n;
  logic        sram_we_n, sram_oe_n, sram_dq_oe;
  logic [31:0] sram_dq_o;
  logic [31:0] sram_dq_i = 32'hEEEEEEEE;

  int checks = 0, fails = 0;
  bit done = 1'b0, contention = 1'b0;
  logic [7:0] mem [logic [18:0]];

  always #10 clk = ~clk;

  sram_lane_ctrl u_sram_lane_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .sram_addr_o(sram_addr), .sram_cs_no(sram_cs_n), .sram_we_no(sram_we_n),
    .sram_oe_no(sram_oe_n), .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe),
    .sram_dq_i(sram_dq_i)
  );

  // memory model: lane written while its select and write enable are low
  always @(posedge clk) begin
    for (int l = 0; l < 4; l++)
      if (!sram_cs_n[l] && !sram_we_n)
        mem[{sram_addr, 2'(l)}] = sram_dq_o[l*8 +: 8];
  end

  // lane drives only with select low, write enable high, output enable low
  always @(negedge clk) begin
    for (int l = 0; l < 4; l++) begin
      if (!sram_cs_n[l] && sram_we_n && !sram_oe_n) begin
        sram_dq_i[l*8 +: 8] = mem.exists({sram_addr, 2'(l)}) ?
                              mem[{sram_addr, 2'(l)}] : 8'h00;
        if (sram_dq_oe) contention = 1'b1;
      end else begin
        sram_dq_i[l*8 +: 8] = 8'hEE;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pins_idle(input string req);
    chk(sram_cs_n == 4'hF, req, 32'(sram_cs_n), 32'hF);
    chk(sram_we_n && sram_oe_n && !sram_dq_oe, req,
        {29'd0, sram_we_n, sram_oe_n, sram_dq_oe}, 32'h6);
  endtask

  task automatic do_op(input vec_t v);
    int we_lo = 0, oe_lo = 0;
    chk(req_ready, "R1 ready before request", 32'(req_ready), 1);
    req_valid = 1'b1; req_we = v.we; req_addr = v.addr;
    req_wdata = v.wdata; req_be = v.be;
    @(posedge clk);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      chk(req_ready == (k == 6), "R1 ready window", 32'(req_ready), 32'(k == 6));
      if (v.we) begin
        if (!sram_we_n) we_lo++;
        if (k <= 3) chk(sram_cs_n == ~v.be, "R8 lane selects in write",
                        32'(sram_cs_n), 32'(~v.be));
        if (k <= 4) chk(sram_addr == v.addr && sram_dq_o == v.wdata,
                        "R3 address/data held", sram_dq_o, v.wdata);
        if (k == 1) chk(sram_we_n && sram_dq_oe, "R2 setup phase",
                        {sram_we_n, sram_dq_oe}, 2'b11);
        if (k == 4) chk(sram_cs_n == 4'hF && sram_we_n && sram_dq_oe,
                        "R2 hold phase", {sram_cs_n, sram_we_n, sram_dq_oe}, 6'h3F);
        if (k == 5) chk(!sram_dq_oe, "R2 bus released in recovery", 32'(sram_dq_oe), 0);
      end else begin
        if (!sram_oe_n) oe_lo++;
        chk(sram_we_n && !sram_dq_oe, "R5 R4 read keeps we high, bus released",
            {sram_we_n, sram_dq_oe}, 2'b10);
        if (k <= 4) chk(sram_cs_n == ~v.be, "R5 R8 lane selects in read",
                        32'(sram_cs_n), 32'(~v.be));
        if (k == 1) chk(sram_oe_n, "R4 turnaround before output enable", 32'(sram_oe_n), 1);
        chk(rd_valid == (k == 5), "R6 one-cycle read strobe", 32'(rd_valid), 32'(k == 5));
        if (k == 5) chk(rd_data == v.exp, "R6 read data", rd_data, v.exp);
      end
    end
    if (v.we) chk(we_lo == 2, "R7 write pulse cycles", 32'(we_lo), 2);
    else      chk(oe_lo == 3, "R7 access cycles", 32'(oe_lo), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready && !rd_valid, "R1 reset state", {req_ready, rd_valid}, 2'b10);
    pins_idle("R1 reset pins");

    // no request: pins stay deselected
    repeat (3) @(negedge clk);
    pins_idle("R1 idle without request");

    foreach (VECS[i]) do_op(VECS[i]);

    chk(!contention, "R4 no bus contention", 32'(contention), 0);

    // reset in the middle of a write pulse
    req_valid = 1'b1; req_we = 1'b1; req_addr = 17'h00020;
    req_wdata = 32'h99999999; req_be = 4'hF;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    chk(!sram_we_n, "R9 pulse active before reset", 32'(sram_we_n), 0);
    rst_ni = 1'b0;
    #1;
    pins_idle("R9 async reset mid-pulse");
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready && !rd_valid, "R9 idle after reset", {req_ready, rd_valid}, 2'b10);
    pins_idle("R9 pins after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule